// File: doc/BRIEF.md
# Display Memory Address Remapper

This block turns a display memory offset and a plane number into the final plane-memory address that a video memory array sees. It also reports whether that address falls inside the installed memory. Accesses come from one of two sides. Accesses from the CPU side keep their offset exactly as given. Accesses from the screen refresh engine may have the offset changed twice, and always in the same order.

The first change is a word-mode fold. When the address unit runs in word mode, address bit 0 is replaced by a higher offset bit: bit 15 or bit 13, picked by a control bit. The second change is a row-scan substitution. Each of address lines 13 and 14 can take a low bit of the character row scan counter in place of the offset bit. This lets a frame buffer be interleaved two or four ways by scan line.

The plane number sits above the 16-bit offset to form an 18-bit linear address. That address is compared against a memory size limit. The memory wrapper uses the resulting flag to return zero on out-of-range reads and to drop out-of-range writes. A parameter picks between a purely combinational path and one with a single output register stage. The register stage is the default.

Top module: `dispaddr_remap`

## Requirements
- R1: When `renderer` is 0, `phys_addr[15:0]` equals `offset`, whatever the mode and substitution controls are.
- R2: For a renderer access with `word_mode`=0, `keep_a13`=1 and `keep_a14`=1, `phys_addr[15:0]` equals `offset`.
- R3: For a renderer access with `word_mode`=1 and `wrap_hi`=1, `phys_addr[0]` equals `offset[15]`.
- R4: For a renderer access with `word_mode`=1 and `wrap_hi`=0, `phys_addr[0]` equals `offset[13]`. This is the offset bit as given, because the fold happens before any row-scan substitution.
- R5: For a renderer access with `keep_a13`=0, `phys_addr[13]` equals `row_lsb[0]`.
- R6: For a renderer access with `keep_a14`=0, `phys_addr[14]` equals `row_lsb[1]`.
- R7: For a renderer access, `phys_addr` bits 1 to 12 and bit 15 equal the same bits of `offset`.
- R8: `phys_addr[17:16]` equals `plane`.
- R9: `in_range` is 1 exactly when `phys_addr` is strictly below `mem_limit`. A limit of 0 makes every address out of range.
- R10: With the default registered stage, outputs follow the inputs one clock later. While `rst` is high at a clock edge, the outputs become `phys_addr`=0 and `in_range`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| offset | input | 16 | Display memory offset |
| plane | input | 2 | Plane number |
| row_lsb | input | 2 | Low two bits of the row scan counter |
| renderer | input | 1 | 1 = refresh-engine access, 0 = CPU-side access |
| word_mode | input | 1 | 1 = address unit in word mode |
| wrap_hi | input | 1 | Word mode: 1 folds offset bit 15 into bit 0, 0 folds bit 13 |
| keep_a13 | input | 1 | 0 = address bit 13 takes row_lsb[0] |
| keep_a14 | input | 1 | 0 = address bit 14 takes row_lsb[1] |
| mem_limit | input | 19 | Installed memory size in bytes |
| phys_addr | output | 18 | Plane-memory address |
| in_range | output | 1 | Address lies below mem_limit |

## Verification
On every clock, the assertions compare the outputs against the inputs from the cycle before. They check the CPU bypass, the byte-mode passthrough, which bit the fold picks, both row-scan substitutions, the untouched middle bits, the plane field and the range flag.

Some behaviours cannot be stated as a single-cycle property, so only the bench scenarios show them:
- the stage order when bit 13 is both the fold source and a substitution target;
- the exact limit boundary at a plane edge;
- the reset values;
- the point in time at which a new input appears at the outputs.

The bench also sweeps every control combination and row-scan value against its own model.

// File: rtl/dispaddr_pkg.sv
package dispaddr_pkg;
    localparam int OFFS_W  = 16;
    localparam int PLANE_W = 2;
    localparam int SUB_N   = 2;               // number of row-scan substituted lines
    localparam int SUB_LSB = 13;              // lowest substituted address line
    localparam int FOLD_HI = 15;              // fold source when wrap_hi = 1
    localparam int FOLD_LO = 13;              // fold source when wrap_hi = 0
    localparam int ADDR_W  = OFFS_W + PLANE_W;
    localparam int LIMIT_W = ADDR_W + 1;

    typedef logic [OFFS_W-1:0]  offs_t;
    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [LIMIT_W-1:0] limit_t;

    typedef enum logic {SRC_CPU = 1'b0, SRC_RENDER = 1'b1} src_e;

    typedef struct packed {
        logic             word_mode;
        logic             wrap_hi;
        logic [SUB_N-1:0] keep;
    } ctrl_t;

    typedef struct packed {
        addr_t addr;
        logic  in_range;
    } result_t;

    function automatic logic below_limit(addr_t a, limit_t lim);
        return {1'b0, a} < lim;
    endfunction
endpackage

// File: rtl/dispaddr_wrap.sv
module dispaddr_wrap #(
    parameter int W      = 16,
    parameter int HI_BIT = 15,
    parameter int LO_BIT = 13
) (
    input  logic         en,
    input  logic         word_mode,
    input  logic         wrap_hi,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_comb begin
        q = d;
        if (en && word_mode)
            q[0] = wrap_hi ? d[HI_BIT] : d[LO_BIT];
    end
endmodule

// File: rtl/dispaddr_rowsub.sv
module dispaddr_rowsub #(
    parameter int W    = 16,
    parameter int N    = 2,
    parameter int BASE = 13
) (
    input  logic         en,
    input  logic [N-1:0] keep,
    input  logic [N-1:0] rs,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int TOP = BASE + N;

    assign q[BASE-1:0] = d[BASE-1:0];

    for (genvar i = 0; i < N; i++) begin : g_line
        assign q[BASE+i] = (en && !keep[i]) ? rs[i] : d[BASE+i];
    end

    if (TOP < W) begin : g_upper
        assign q[W-1:TOP] = d[W-1:TOP];
    end
endmodule

// File: rtl/dispaddr_linear.sv
module dispaddr_linear
    import dispaddr_pkg::*;
(
    input  logic [PLANE_W-1:0] plane,
    input  offs_t              offs,
    input  limit_t             limit,
    output result_t            res
);
    always_comb begin
        res.addr     = {plane, offs};
        res.in_range = below_limit(res.addr, limit);
    end
endmodule

// File: rtl/dispaddr_remap.sv
module dispaddr_remap
    import dispaddr_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [OFFS_W-1:0]  offset,
    input  logic [PLANE_W-1:0] plane,
    input  logic [SUB_N-1:0]   row_lsb,
    input  logic               renderer,
    input  logic               word_mode,
    input  logic               wrap_hi,
    input  logic               keep_a13,
    input  logic               keep_a14,
    input  logic [LIMIT_W-1:0] mem_limit,
    output logic [ADDR_W-1:0]  phys_addr,
    output logic               in_range
);
    src_e    src;
    ctrl_t   ctrl;
    offs_t   folded;
    offs_t   patched;
    result_t comb_res;
    result_t out_res;

    assign src  = src_e'(renderer);
    assign ctrl = '{word_mode: word_mode, wrap_hi: wrap_hi, keep: {keep_a14, keep_a13}};

    // stage 1: word-mode fold, stage 2: row-scan substitution (fixed order)
    dispaddr_wrap #(.W(OFFS_W), .HI_BIT(FOLD_HI), .LO_BIT(FOLD_LO)) u_wrap (
        .en        (src == SRC_RENDER),
        .word_mode (ctrl.word_mode),
        .wrap_hi   (ctrl.wrap_hi),
        .d         (offset),
        .q         (folded)
    );

    dispaddr_rowsub #(.W(OFFS_W), .N(SUB_N), .BASE(SUB_LSB)) u_rowsub (
        .en   (src == SRC_RENDER),
        .keep (ctrl.keep),
        .rs   (row_lsb),
        .d    (folded),
        .q    (patched)
    );

    dispaddr_linear u_linear (
        .plane (plane),
        .offs  (patched),
        .limit (mem_limit),
        .res   (comb_res)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) out_res <= '0;
            else     out_res <= comb_res;
        end
    end else begin : g_comb
        assign out_res = comb_res;
    end

    assign phys_addr = out_res.addr;
    assign in_range  = out_res.in_range;
endmodule

// File: rtl/dispaddr_remap_chk.sv
module dispaddr_remap_chk
    import dispaddr_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic               clk,
    input logic               rst,
    input logic [OFFS_W-1:0]  offset,
    input logic [PLANE_W-1:0] plane,
    input logic [SUB_N-1:0]   row_lsb,
    input logic               renderer,
    input logic               word_mode,
    input logic               wrap_hi,
    input logic               keep_a13,
    input logic               keep_a14,
    input logic [LIMIT_W-1:0] mem_limit,
    input logic [ADDR_W-1:0]  phys_addr,
    input logic               in_range
);
    // inputs aligned to the cycle in which their result is on the outputs
    logic [OFFS_W-1:0]  c_ofs;
    logic [PLANE_W-1:0] c_pl;
    logic [SUB_N-1:0]   c_rs;
    logic               c_rend, c_wm, c_hi, c_k13, c_k14;
    logic [LIMIT_W-1:0] c_lim;

    if (REG_OUT) begin : g_align
        always_ff @(posedge clk) begin
            if (rst) begin
                c_ofs <= '0; c_pl <= '0; c_rs <= '0; c_rend <= 1'b0; c_wm <= 1'b0;
                c_hi <= 1'b0; c_k13 <= 1'b0; c_k14 <= 1'b0; c_lim <= '0;
            end else begin
                c_ofs <= offset; c_pl <= plane; c_rs <= row_lsb; c_rend <= renderer;
                c_wm <= word_mode; c_hi <= wrap_hi; c_k13 <= keep_a13;
                c_k14 <= keep_a14; c_lim <= mem_limit;
            end
        end
    end else begin : g_direct
        assign c_ofs = offset;   assign c_pl = plane;      assign c_rs = row_lsb;
        assign c_rend = renderer; assign c_wm = word_mode; assign c_hi = wrap_hi;
        assign c_k13 = keep_a13; assign c_k14 = keep_a14;  assign c_lim = mem_limit;
    end

    a_r1_cpu_bypass: assert property (@(posedge clk) disable iff (rst)
        !c_rend |-> phys_addr[OFFS_W-1:0] == c_ofs);

    a_r2_byte_passthru: assert property (@(posedge clk) disable iff (rst)
        (c_rend && !c_wm && c_k13 && c_k14) |-> phys_addr[OFFS_W-1:0] == c_ofs);

    a_r3_fold_hi: assert property (@(posedge clk) disable iff (rst)
        (c_rend && c_wm && c_hi) |-> phys_addr[0] == c_ofs[FOLD_HI]);

    a_r4_fold_lo: assert property (@(posedge clk) disable iff (rst)
        (c_rend && c_wm && !c_hi) |-> phys_addr[0] == c_ofs[FOLD_LO]);

    a_r5_line13: assert property (@(posedge clk) disable iff (rst)
        (c_rend && !c_k13) |-> phys_addr[SUB_LSB] == c_rs[0]);

    a_r6_line14: assert property (@(posedge clk) disable iff (rst)
        (c_rend && !c_k14) |-> phys_addr[SUB_LSB+1] == c_rs[1]);

    a_r7_middle_bits: assert property (@(posedge clk) disable iff (rst)
        c_rend |-> (phys_addr[SUB_LSB-1:1] == c_ofs[SUB_LSB-1:1])
                   && (phys_addr[OFFS_W-1] == c_ofs[OFFS_W-1]));

    a_r8_plane_field: assert property (@(posedge clk) disable iff (rst)
        phys_addr[ADDR_W-1:OFFS_W] == c_pl);

    a_r9_range_flag: assert property (@(posedge clk) disable iff (rst)
        in_range == ({1'b0, phys_addr} < c_lim));
endmodule

bind dispaddr_remap dispaddr_remap_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk(clk), .rst(rst), .offset(offset), .plane(plane), .row_lsb(row_lsb),
    .renderer(renderer), .word_mode(word_mode), .wrap_hi(wrap_hi),
    .keep_a13(keep_a13), .keep_a14(keep_a14), .mem_limit(mem_limit),
    .phys_addr(phys_addr), .in_range(in_range)
);

// File: tb/dispaddr_remap_bench.sv
`timescale 1ns/1ps
module dispaddr_remap_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] offset = '0;
    logic [1:0]  plane = '0;
    logic [1:0]  row_lsb = '0;
    logic        renderer = 1'b0, word_mode = 1'b0, wrap_hi = 1'b0;
    logic        keep_a13 = 1'b1, keep_a14 = 1'b1;
    logic [18:0] mem_limit = '0;
    logic [17:0] phys_addr;
    logic        in_range;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dispaddr_remap u_dispaddr_remap (
        .clk(clk), .rst(rst), .offset(offset), .plane(plane), .row_lsb(row_lsb),
        .renderer(renderer), .word_mode(word_mode), .wrap_hi(wrap_hi),
        .keep_a13(keep_a13), .keep_a14(keep_a14), .mem_limit(mem_limit),
        .phys_addr(phys_addr), .in_range(in_range)
    );

    typedef struct packed {
        logic [15:0] ofs;
        logic [1:0]  pl;
        logic [1:0]  rs;
        logic        rend, wm, hi, k13, k14;
        logic [18:0] lim;
        logic [17:0] exp_addr;
        logic        exp_inr;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{16'h1234, 2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 19'h40000, 18'h11234, 1'b1, 8'd1}, // R1
        '{16'hFFFF, 2'd3, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 19'h40000, 18'h3FFFF, 1'b1, 8'd2}, // R2
        '{16'h0000, 2'd0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 19'h40000, 18'h06000, 1'b1, 8'd5}, // R5
        '{16'h6000, 2'd2, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 19'h40000, 18'h24000, 1'b1, 8'd5}, // R5
        '{16'h8000, 2'd0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 19'h40000, 18'h08001, 1'b1, 8'd3}, // R3
        '{16'h2002, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 19'h40000, 18'h02003, 1'b1, 8'd4}, // R4
        '{16'h2000, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 19'h40000, 18'h00001, 1'b1, 8'd4}, // R4 order
        '{16'h0001, 2'd0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 19'h40000, 18'h00000, 1'b1, 8'd3}, // R3
        '{16'hFFFF, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 19'h20000, 18'h1FFFF, 1'b1, 8'd9}, // R9
        '{16'h0000, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 19'h20000, 18'h20000, 1'b0, 8'd9}, // R9
        '{16'h0000, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 19'h00000, 18'h00000, 1'b0, 8'd9}, // R9
        '{16'h2000, 2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 19'h40000, 18'h02000, 1'b1, 8'd1}, // R1
        '{16'h0000, 2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 19'h40000, 18'h14000, 1'b1, 8'd6}, // R6
        '{16'h1FFE, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 19'h40000, 18'h01FFE, 1'b1, 8'd7}  // R7
    };

    // independent model of the requirements
    function automatic logic [17:0] model(logic [15:0] o, logic [1:0] p, logic [1:0] r,
                                          logic rd, logic wm, logic hi, logic k13, logic k14);
        logic [15:0] t;
        t = o;
        if (rd) begin
            if (wm) t[0] = hi ? o[15] : o[13];
            if (!k13) t[13] = r[0];
            if (!k14) t[14] = r[1];
        end
        return {p, t};
    endfunction

    task automatic drive(logic [15:0] o, logic [1:0] p, logic [1:0] r, logic rd,
                         logic wm, logic hi, logic k13, logic k14, logic [18:0] lim);
        @(negedge clk);
        offset = o; plane = p; row_lsb = r; renderer = rd; word_mode = wm;
        wrap_hi = hi; keep_a13 = k13; keep_a14 = k14; mem_limit = lim;
        @(negedge clk);
    endtask

    task automatic check(string tag, logic [17:0] ea, logic ei);
        checks++;
        if (phys_addr !== ea || in_range !== ei) begin
            errors++;
            $display("FAIL %s: addr=%h in_range=%b expected addr=%h in_range=%b",
                     tag, phys_addr, in_range, ea, ei);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        repeat (3) @(negedge clk);
        check("R10 reset", 18'h0, 1'b0);
        rst = 1'b0;

        // table walk
        foreach (VECS[i]) begin
            drive(VECS[i].ofs, VECS[i].pl, VECS[i].rs, VECS[i].rend, VECS[i].wm,
                  VECS[i].hi, VECS[i].k13, VECS[i].k14, VECS[i].lim);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].exp_addr, VECS[i].exp_inr);
        end

        // exhaustive control sweep: R1 R2 R3 R4 R5 R6 R7 R8
        for (int c = 0; c < 32; c++) begin
            for (int r = 0; r < 4; r++) begin
                for (int k = 0; k < 3; k++) begin
                    logic [15:0] o;
                    logic [1:0]  p;
                    logic [17:0] e;
                    o = (k == 0) ? 16'hA5A5 : (k == 1) ? 16'h2000 : 16'h5FFE;
                    p = 2'(c + k);
                    e = model(o, p, 2'(r), c[4], c[3], c[2], c[1], c[0]);
                    drive(o, p, 2'(r), c[4], c[3], c[2], c[1], c[0], 19'h40000);
                    check("R1-R8 sweep (R5 R6 R7 R8)", e, 1'b1);
                end
            end
        end

        // R10 latency: new input not visible before the next edge
        @(negedge clk);
        offset = 16'h0F0F; plane = 2'd3; renderer = 1'b0; mem_limit = 19'h40000;
        #1;
        check("R10 held before edge", 18'h15FFE, 1'b1);
        @(negedge clk);
        check("R10 after one edge", 18'h30F0F, 1'b1);

        // R10 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R10 mid-run reset", 18'h0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R10 resume after reset", 18'h30F0F, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule